// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus master controller and a bus target controller over a single request line and a single acknowledge line. Each handshake moves exactly one word. Neither controller assumes anything about the other's timing. Every control line that crosses between the two sides first passes through a two-flop synchronizer. The link therefore behaves like an unclocked bus, even though both controllers run on one clock here.

A local agent asks for a transfer by pulsing `start` with a direction, an address and, for a write, a data word. The master places the command on the bus and holds it there. It waits a fixed number of cycles so the target can decode the address, and then raises the request. The target waits its own response delay before it acts. It then stores the write word, or presents the read word, and raises the acknowledge. When the master sees the acknowledge, it drops the request and, on a read, takes the data. The target drops the acknowledge once the request has gone low. When the master sees the acknowledge low, it reports `done` and may accept its next command. The target keeps a small word store. Reads and writes reach that store through the link.

Master states: `M_IDLE`, `M_DECODE`, `M_REQ`, `M_RELEASE`. The master transitions are:
- `M_IDLE` to `M_DECODE` when `start` is high. This is the accept.
- `M_DECODE` to `M_REQ` when the decode count ends.
- `M_REQ` to `M_RELEASE` when the synchronized acknowledge is high.
- `M_RELEASE` to `M_IDLE` when the synchronized acknowledge is low.

Target states: `S_IDLE`, `S_DELAY`, `S_ACK`. The target transitions are:
- `S_IDLE` to `S_DELAY` when the synchronized request is high.
- `S_DELAY` to `S_ACK` when the response count ends.
- `S_ACK` to `S_IDLE` when the synchronized request is low.

Top module: `hs_bus_link`

## Requirements
- R1: The master loads `wr`, `addr` and `wdata` on the edge that samples `start` high while it is idle (the accept edge, cycle 0). It holds the loaded command unchanged on the bus until it returns to idle.
- R2: `bus_req` goes high exactly DECODE_CYC cycles after the accept edge (default 2).
- R3: The target raises `bus_ack` RESP_DELAY cycles after it first sees the synchronized request, which is DECODE_CYC+3+RESP_DELAY cycles after accept. On a write, the target stores the word in its store on that same edge.
- R4: The master drops `bus_req` one cycle after the synchronized acknowledge is high, which is DECODE_CYC+6+RESP_DELAY cycles after accept. On a read, `rdata` takes the addressed word on that same edge. Otherwise `rdata` keeps its previous value, including across write transfers.
- R5: The target drops `bus_ack` one cycle after the synchronized request is low, which is DECODE_CYC+9+RESP_DELAY cycles after accept.
- R6: `done` is a single-cycle pulse DECODE_CYC+12+RESP_DELAY cycles after accept. `busy` is high from the accept until that edge. The master raises no new request while the acknowledge is still high.
- R7: A `start` pulse while `busy` is high is ignored. It changes no stored word and does not alter the timing of the transfer in progress.
- R8: The master accepts a new command on the first edge after `done`, so transfers can run back to back.
- R9: Read data from the target stays stable while `bus_ack` is high.
- R10: After reset, `busy`, `done`, `bus_req`, `bus_ack` and `rdata` are 0, and every stored word reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both controllers |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one transfer; sampled only while idle |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr | input | ADDR_W | Word address in the target store |
| wdata | input | DATA_W | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rdata | output | DATA_W | Last word read |
| bus_req | output | 1 | Request line as driven by the master |
| bus_ack | output | 1 | Acknowledge line as driven by the target |

## Verification
With the default parameters, every result falls at a fixed offset from the accept edge. The request rises at cycle 2 and the acknowledge at cycle 8. The request falls and read data lands at cycle 11, the acknowledge falls at cycle 14, and `done` pulses at cycle 17. The bench keeps a behavioural model that counts cycles from the accept and holds a word array. From these it predicts each output for every cycle of a transfer. It compares all outputs half a clock after each edge, so every register on the path has settled. Stray `start` pulses sent during a transfer are followed by read-backs of the targeted address, so an ignored write shows up at the `rdata` port.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_DECODE  = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } master_state_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DELAY = 2'd1,
        S_ACK   = 2'd2
    } slave_state_e;

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic sync_q;

    // Two-stage synchronizer: first stage may be metastable, second is used.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int DECODE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_in,
    input  logic [DATA_W-1:0] rd_bus,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              req_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam int CNT_W = $clog2(DECODE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECODE_CYC - 1);

    master_state_e state_q, state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic              req_q, done_q, wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            M_IDLE:    if (start)            state_n = M_DECODE;
            M_DECODE:  if (cnt_q == CNT_LAST) state_n = M_REQ;
            M_REQ:     if (ack_in)           state_n = M_RELEASE;
            M_RELEASE: if (!ack_in)          state_n = M_IDLE;
            default:                         state_n = M_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_n;
    end

    // Registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            req_q   <= 1'b0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            req_q  <= (state_n == M_REQ);
            done_q <= (state_q == M_RELEASE) && !ack_in;
            cnt_q  <= (state_q == M_DECODE) ? cnt_q + 1'b1 : '0;
            if (state_q == M_IDLE && start) begin
                wr_q    <= wr;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state_q == M_REQ && ack_in && !wr_q)
                rdata_q <= rd_bus;
        end
    end

    assign busy    = (state_q != M_IDLE);
    assign done    = done_q;
    assign rdata   = rdata_q;
    assign req_o   = req_q;
    assign wr_o    = wr_q;
    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;

    // R1: command on the bus stays fixed for the whole transfer
    p_cmd_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != M_IDLE && $past(state_q) != M_IDLE)
            |-> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));

    // R4: request falls only after the synchronized acknowledge was seen
    p_req_drop_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(ack_in));

    // R6: no new request while the acknowledge is still high
    p_no_req_while_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> !ack_in);

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int RESP_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_in,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack_o,
    output logic [DATA_W-1:0] rd_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(RESP_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESP_DELAY - 1);

    slave_state_e state_q, state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              respond;

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:  if (req_in)             state_n = S_DELAY;
            S_DELAY: if (cnt_q == CNT_LAST)  state_n = S_ACK;
            S_ACK:   if (!req_in)            state_n = S_IDLE;
            default:                         state_n = S_IDLE;
        endcase
    end

    assign respond = (state_q == S_DELAY) && (state_n == S_ACK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // Registered outputs and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
            rd_q  <= '0;
        end else begin
            ack_q <= (state_n == S_ACK);
            cnt_q <= (state_q == S_DELAY) ? cnt_q + 1'b1 : '0;
            if (respond && !wr)
                rd_q <= mem_q[addr];
        end
    end

    // Word store, one register per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (respond && wr && addr == ADDR_W'(g))
                mem_q[g] <= wdata;
        end
    end

    assign ack_o = ack_q;
    assign rd_o  = rd_q;

    // R3: acknowledge rises only while the request is seen high
    p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(req_in));

    // R5: acknowledge falls only after the request was seen low
    p_ack_drop_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(req_in));

    // R9: read word held while acknowledging
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && $past(ack_q)) |-> $stable(rd_q));
endmodule

// File: rtl/hs_bus_link.sv
module hs_bus_link #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int DECODE_CYC = 2,
    parameter int RESP_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_ack
);
    logic              req_line, ack_line;
    logic              req_seen, ack_seen;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [DATA_W-1:0] rd_line;

    hs_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE_CYC)
    ) u_master (
        .clk(clk), .rst_n(rst_n),
        .start(start), .wr(wr), .addr(addr), .wdata(wdata),
        .ack_in(ack_seen), .rd_bus(rd_line),
        .busy(busy), .done(done), .rdata(rdata),
        .req_o(req_line), .wr_o(cmd_wr), .addr_o(cmd_addr), .wdata_o(cmd_wdata)
    );

    hs_sync2 u_req_sync (.clk(clk), .rst_n(rst_n), .d(req_line), .q(req_seen));
    hs_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_line), .q(ack_seen));

    hs_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESP_DELAY(RESP_DELAY)
    ) u_slave (
        .clk(clk), .rst_n(rst_n),
        .req_in(req_seen), .wr(cmd_wr), .addr(cmd_addr), .wdata(cmd_wdata),
        .ack_o(ack_line), .rd_o(rd_line)
    );

    assign bus_req = req_line;
    assign bus_ack = ack_line;
endmodule

// File: tb/tb_hs_bus_link.sv
module tb_hs_bus_link;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DC = 2;
    localparam int RD = 3;
    localparam int T_ACK_UP = DC + 3 + RD;
    localparam int T_REQ_DN = DC + 6 + RD;
    localparam int T_ACK_DN = DC + 9 + RD;
    localparam int T_DONE   = DC + 12 + RD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          busy, done, bus_req, bus_ack;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model_mem [1 << AW];
    logic [DW-1:0] exp_rd = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    hs_bus_link #(.ADDR_W(AW), .DATA_W(DW), .DECODE_CYC(DC), .RESP_DELAY(RD)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_req(bus_req), .bus_ack(bus_ack)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One transfer; compares every output on every cycle until done.
    // stray_k >= 0 drives an extra start (a write) at that offset.
    task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int stray_k, input logic [AW-1:0] sa, input logic [DW-1:0] sd);
        start = 1'b1; wr = w; addr = a; wdata = d;
        @(posedge clk);              // accept edge, offset 0
        @(negedge clk);
        start = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        for (int k = 0; k <= T_DONE; k++) begin
            if (w && k == T_ACK_UP) model_mem[a] = d;
            if (!w && k == T_REQ_DN) exp_rd = model_mem[a];
            chk("R2", "bus_req", int'(bus_req), int'(k >= DC && k < T_REQ_DN));
            chk("R3", "bus_ack", int'(bus_ack), int'(k >= T_ACK_UP && k < T_ACK_DN));
            chk("R4", "rdata", int'(rdata), int'(exp_rd));
            chk("R6", "busy", int'(busy), int'(k < T_DONE));
            chk("R6", "done", int'(done), int'(k == T_DONE));
            if (k == T_ACK_DN)
                chk("R5", "ack low at drop", int'(bus_ack), 0);
            if (k == stray_k) begin
                start = 1'b1; wr = 1'b1; addr = sa; wdata = sd;   // R7 stray
            end else if (k == stray_k + 1) begin
                start = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
            end
            if (k < T_DONE) @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "done", int'(done), 0);
        chk("R10", "bus_req", int'(bus_req), 0);
        chk("R10", "bus_ack", int'(bus_ack), 0);
        chk("R10", "rdata", int'(rdata), 0);
        // R10: unwritten word reads 0 (first set rdata nonzero to make it visible)
        xfer(1'b1, 4'd2, 8'h11, -5, '0, '0);
        xfer(1'b0, 4'd2, 8'h00, -5, '0, '0);
        xfer(1'b0, 4'd5, 8'h00, -5, '0, '0);
        chk("R10", "reset word", int'(rdata), 0);
        // R1/R3 writes, R8 back-to-back, R4 rdata kept across writes
        xfer(1'b1, 4'd5, 8'hA5, -5, '0, '0);
        xfer(1'b1, 4'd9, 8'h3C, -5, '0, '0);
        xfer(1'b0, 4'd5, 8'h00, -5, '0, '0);
        chk("R1", "write 5 stored", int'(rdata), 8'hA5);
        // R7: stray start during a read must not write 9
        xfer(1'b0, 4'd9, 8'h00, 4, 4'd9, 8'hFF);
        chk("R4", "read 9", int'(rdata), 8'h3C);
        xfer(1'b0, 4'd9, 8'h00, -5, '0, '0);
        chk("R7", "stray ignored", int'(rdata), 8'h3C);
        // R7: stray during a write near the end, to another address
        xfer(1'b1, 4'd15, 8'h81, 12, 4'd3, 8'h77);
        xfer(1'b0, 4'd3, 8'h00, -5, '0, '0);
        chk("R7", "stray addr 3", int'(rdata), 0);
        xfer(1'b0, 4'd15, 8'h00, -5, '0, '0);
        chk("R9", "read 15", int'(rdata), 8'h81);
        // idle afterwards: no activity
        repeat (4) @(negedge clk);
        chk("R6", "idle busy", int'(busy), 0);
        chk("R6", "idle req", int'(bus_req), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule